// File: doc/BRIEF.md
# Wide Register Write Collector

This block sits on the write side of a 32-bit host register bus in front of a register space whose registers are mostly 128 bits wide, plus a region of 64-bit memory words. The host can only deliver one dword per write. The block gathers those dwords in a single shared collector and issues one atomic wide write toward the register file or memory once the target is complete. Plain 32-bit per-page registers bypass the collector and are forwarded unchanged.

Per-queue registers are paged. The page number is the address shifted right by 13 (a page is 0x2000 bytes), and the low 13 bits are the offset within the page. The two descriptor-pointer registers in every page are handled so that a host can update them without a lock. Writing their top dword always commits them, and any lower dword the collector does not hold for that register is zero-filled. Their lower dwords are dropped when the collector is busy with a different target. A write to the timer command register in page 0 empties the collector. There is only one collector, so interleaved partial writes to two wide targets lose data. This is intended behaviour, and the block reproduces it.

Top module: `wide_write_collector`

## Requirements
- R1: After synchronous reset `wide_we` and `narrow_we` are 0 and the collector is empty, so a descriptor top-dword write that follows carries zero in its three lower dwords.
- R2: An ordinary 128-bit register (address below the memory base, not a descriptor or direct offset) commits one cycle after the last of its four dwords arrives, in any order. Dword n, selected by address bits [3:2], lands in `wide_data[32n+31:32n]`, `wide_addr` is 16-byte aligned, and `wide_kind` is 0.
- R3: Fewer than four dwords of an ordinary register produce no commit, and a repeated write to the same dword replaces the earlier value.
- R4: A dword written to a different wide target restarts the collector with only that dword, and the dwords held earlier are lost.
- R5: Addresses at or above the memory base (0x800000) are 64-bit words. A word commits when both of its dwords are present, selected by address bit 2. The commit has `wide_kind` 1, an 8-byte aligned address, the word in `wide_data[63:0]`, and zero in bits 127:64.
- R6: The descriptor registers sit at in-page offsets 0x830 and 0xa10. A write to the top dword (offset + 12) always commits with `wide_kind` 2. Lower dwords that the collector holds for that same register are kept, and all other lower dwords are zero.
- R7: A non-top descriptor dword written while the collector holds dwords of a different target is discarded, and the collector keeps its contents.
- R8: Writes to in-page offsets 0x400 and 0x420 appear one cycle later on `narrow_we`, `narrow_addr` and `narrow_data`, with no wide commit. Outside the page-0 timer case they leave the collector unchanged.
- R9: A write to offset 0x420 in page 0 (address 0x420) empties the collector.
- R10: `wide_we` is a one-cycle pulse per commit, and the collector is empty after any commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Host dword write strobe |
| host_addr | input | 24 | Host byte address |
| host_wdata | input | 32 | Host write data |
| wide_we | output | 1 | One-cycle atomic wide write strobe |
| wide_addr | output | 24 | Aligned byte address of the wide write |
| wide_data | output | 128 | Wide write data |
| wide_kind | output | 2 | Target class: 0 register, 1 memory word, 2 descriptor |
| narrow_we | output | 1 | Direct 32-bit write strobe |
| narrow_addr | output | 24 | Direct write address |
| narrow_data | output | 32 | Direct write data |

## Verification
A wrong valid mask or tag does not show up at the ports until a later write completes or misses a target. A stale bit shows as a commit one dword early, or as a missing commit after the fourth dword. A bad tag compare shows as dwords from an earlier target leaking into `wide_data`. The bench therefore follows each manipulation of collector state, whether a restart, a discarded descriptor dword, a direct write or a timer clear, with the writes that complete a target. It compares the whole committed word in the cycle after the completing write, so corrupt state shows within a few writes of its cause.

// File: rtl/wwc_pkg.sv
package wwc_pkg;
  localparam int DW    = 32;
  localparam int LANES = 4;
  localparam int WIDE_W = DW * LANES;

  typedef enum logic [1:0] {
    KIND_REG128 = 2'd0,
    KIND_SRAM64 = 2'd1,
    KIND_DESC   = 2'd2,
    KIND_NARROW = 2'd3
  } wkind_e;
endpackage

// File: rtl/wwc_decode.sv
module wwc_decode
  import wwc_pkg::*;
#(
  parameter int ADDR_W              = 24,
  parameter int PAGE_SHIFT          = 13,
  parameter int unsigned MEM_BASE   = 32'h0080_0000,
  parameter int unsigned RXD_OFF    = 32'h830,
  parameter int unsigned TXD_OFF    = 32'hA10,
  parameter int unsigned DIRECT_OFF = 32'h400,
  parameter int unsigned TIMER_OFF  = 32'h420
) (
  input  logic [ADDR_W-1:0] addr,
  output wkind_e            kind,
  output logic [1:0]        lane,
  output logic              is_top,
  output logic              is_timer0
);
  localparam int PAGE_W = ADDR_W - PAGE_SHIFT;
  localparam int NDESC  = 2;
  localparam logic [PAGE_SHIFT-1:0] DESC_L [NDESC] =
    '{PAGE_SHIFT'(RXD_OFF), PAGE_SHIFT'(TXD_OFF)};
  localparam logic [PAGE_SHIFT-1:0] DIRECT_L = PAGE_SHIFT'(DIRECT_OFF);
  localparam logic [PAGE_SHIFT-1:0] TIMER_L  = PAGE_SHIFT'(TIMER_OFF);
  localparam logic [ADDR_W-1:0]     MEM_L    = ADDR_W'(MEM_BASE);

  logic [PAGE_SHIFT-1:0] off;
  logic [PAGE_W-1:0]     page;
  logic [NDESC-1:0]      desc_hit;
  logic                  in_mem, is_direct, is_timer, unused_low;

  assign off        = addr[PAGE_SHIFT-1:0];
  assign page       = addr[ADDR_W-1:PAGE_SHIFT];
  assign in_mem     = (addr >= MEM_L);
  assign unused_low = ^addr[1:0];

  for (genvar g = 0; g < NDESC; g++) begin : g_desc
    assign desc_hit[g] = (off[PAGE_SHIFT-1:4] == DESC_L[g][PAGE_SHIFT-1:4]);
  end

  assign is_direct = (off[PAGE_SHIFT-1:2] == DIRECT_L[PAGE_SHIFT-1:2]);
  assign is_timer  = (off[PAGE_SHIFT-1:2] == TIMER_L[PAGE_SHIFT-1:2]);

  always_comb begin
    if (in_mem)                     kind = KIND_SRAM64;
    else if (|desc_hit)             kind = KIND_DESC;
    else if (is_direct || is_timer) kind = KIND_NARROW;
    else                            kind = KIND_REG128;
  end

  assign lane      = in_mem ? {1'b0, addr[2]} : addr[3:2];
  assign is_top    = !in_mem && (|desc_hit) && (addr[3:2] == 2'd3);
  assign is_timer0 = !in_mem && is_timer && (page == '0);
endmodule

// File: rtl/wwc_collector.sv
module wwc_collector
  import wwc_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-4:0] wtag,
  input  logic [DW-1:0]     wdata,
  input  wkind_e            kind,
  input  logic [1:0]        lane,
  input  logic              is_top,
  input  logic              is_timer0,
  output logic              commit,
  output logic [ADDR_W-1:0] commit_addr,
  output logic [WIDE_W-1:0] commit_data,
  output wkind_e            commit_kind
);
  localparam int TAG_W = ADDR_W - 3;

  logic [LANES-1:0] valid_q, valid_n;
  logic [TAG_W-1:0] tag_q, tag_n;
  wkind_e           kind_q, kind_n;
  logic [DW-1:0]    data_q [LANES];
  logic [DW-1:0]    merged [LANES];

  logic             busy, hit, same128, same64, load, full;
  logic [LANES-1:0] bitm, mask_w;
  logic [ADDR_W-1:0] a128, a64;

  assign busy    = (valid_q != '0);
  assign same128 = busy && (kind_q == kind) && (tag_q[TAG_W-1:1] == wtag[TAG_W-1:1]);
  assign same64  = busy && (kind_q == KIND_SRAM64) && (tag_q == wtag);
  assign hit     = (kind == KIND_SRAM64) ? same64 : same128;
  assign bitm    = LANES'(1) << lane;
  assign a128    = {wtag[TAG_W-1:1], 4'b0000};
  assign a64     = {wtag, 3'b000};

  for (genvar g = 0; g < LANES; g++) begin : g_merge
    assign merged[g] = (lane == g[1:0]) ? wdata : data_q[g];
  end

  always_comb begin
    valid_n     = valid_q;
    tag_n       = tag_q;
    kind_n      = kind_q;
    load        = 1'b0;
    commit      = 1'b0;
    commit_data = '0;
    commit_addr = '0;
    commit_kind = kind;
    mask_w      = (hit ? valid_q : '0) | bitm;
    full        = (kind == KIND_SRAM64) ? (&mask_w[1:0]) : (&mask_w);
    if (wr_en) begin
      unique case (kind)
        KIND_NARROW: begin
          if (is_timer0) valid_n = '0;
        end
        KIND_DESC: begin
          if (is_top) begin
            commit      = 1'b1;
            commit_addr = a128;
            for (int i = 0; i < LANES - 1; i++)
              commit_data[i*DW +: DW] = (hit && valid_q[i]) ? data_q[i] : '0;
            commit_data[(LANES-1)*DW +: DW] = wdata;
            valid_n = '0;
          end else if (!busy || hit) begin
            load    = 1'b1;
            valid_n = mask_w;
            tag_n   = wtag;
            kind_n  = kind;
          end
        end
        default: begin
          if (full) begin
            commit  = 1'b1;
            valid_n = '0;
            if (kind == KIND_SRAM64) begin
              commit_addr       = a64;
              commit_data[63:0] = {merged[1], merged[0]};
            end else begin
              commit_addr = a128;
              for (int i = 0; i < LANES; i++)
                commit_data[i*DW +: DW] = merged[i];
            end
          end else begin
            load    = 1'b1;
            valid_n = mask_w;
            tag_n   = wtag;
            kind_n  = kind;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      tag_q   <= '0;
      kind_q  <= KIND_REG128;
    end else begin
      valid_q <= valid_n;
      tag_q   <= tag_n;
      kind_q  <= kind_n;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (load && (lane == g[1:0])) data_q[g] <= wdata;
    end
  end

  // R1: reset empties the collector
  a_r1_reset_empty: assert property (@(posedge clk) rst |=> (valid_q == '0));

  // R9: page-0 timer write empties the collector
  a_r9_timer_clears: assert property (@(posedge clk) disable iff (rst)
    (wr_en && is_timer0) |=> (valid_q == '0));

  // R7: a discarded descriptor dword leaves the collector untouched
  a_r7_discard_keeps: assert property (@(posedge clk) disable iff (rst)
    (wr_en && kind == KIND_DESC && !is_top && busy && !hit)
      |=> ($stable(valid_q) && $stable(tag_q)));

  // R10: collector is empty after a commit
  a_r10_empty_after_commit: assert property (@(posedge clk) disable iff (rst)
    commit |=> (valid_q == '0));
endmodule

// File: rtl/wwc_outreg.sv
module wwc_outreg
  import wwc_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit,
  input  logic [ADDR_W-1:0] commit_addr,
  input  logic [WIDE_W-1:0] commit_data,
  input  wkind_e            commit_kind,
  input  logic              direct_en,
  input  logic [ADDR_W-1:0] direct_addr,
  input  logic [DW-1:0]     direct_data,
  output logic              wide_we,
  output logic [ADDR_W-1:0] wide_addr,
  output logic [WIDE_W-1:0] wide_data,
  output logic [1:0]        wide_kind,
  output logic              narrow_we,
  output logic [ADDR_W-1:0] narrow_addr,
  output logic [DW-1:0]     narrow_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      wide_we   <= 1'b0;
      narrow_we <= 1'b0;
    end else begin
      wide_we   <= commit;
      narrow_we <= direct_en;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wide_addr <= '0;
      wide_data <= '0;
      wide_kind <= '0;
    end else if (commit) begin
      wide_addr <= commit_addr;
      wide_data <= commit_data;
      wide_kind <= commit_kind;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      narrow_addr <= '0;
      narrow_data <= '0;
    end else if (direct_en) begin
      narrow_addr <= direct_addr;
      narrow_data <= direct_data;
    end
  end
endmodule

// File: rtl/wide_write_collector.sv
module wide_write_collector
  import wwc_pkg::*;
#(
  parameter int ADDR_W              = 24,
  parameter int PAGE_SHIFT          = 13,
  parameter int unsigned MEM_BASE   = 32'h0080_0000,
  parameter int unsigned RXD_OFF    = 32'h830,
  parameter int unsigned TXD_OFF    = 32'hA10,
  parameter int unsigned DIRECT_OFF = 32'h400,
  parameter int unsigned TIMER_OFF  = 32'h420
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_wr_en,
  input  logic [ADDR_W-1:0]  host_addr,
  input  logic [31:0]        host_wdata,
  output logic               wide_we,
  output logic [ADDR_W-1:0]  wide_addr,
  output logic [127:0]       wide_data,
  output logic [1:0]         wide_kind,
  output logic               narrow_we,
  output logic [ADDR_W-1:0]  narrow_addr,
  output logic [31:0]        narrow_data
);
  wkind_e              dec_kind, c_kind;
  logic [1:0]          dec_lane;
  logic                dec_top, dec_timer0, c_commit;
  logic [ADDR_W-1:0]   c_addr;
  logic [WIDE_W-1:0]   c_data;

  wwc_decode #(
    .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .MEM_BASE(MEM_BASE),
    .RXD_OFF(RXD_OFF), .TXD_OFF(TXD_OFF),
    .DIRECT_OFF(DIRECT_OFF), .TIMER_OFF(TIMER_OFF)
  ) u_decode (
    .addr(host_addr), .kind(dec_kind), .lane(dec_lane),
    .is_top(dec_top), .is_timer0(dec_timer0)
  );

  wwc_collector #(.ADDR_W(ADDR_W)) u_coll (
    .clk(clk), .rst(rst), .wr_en(host_wr_en),
    .wtag(host_addr[ADDR_W-1:3]), .wdata(host_wdata),
    .kind(dec_kind), .lane(dec_lane), .is_top(dec_top), .is_timer0(dec_timer0),
    .commit(c_commit), .commit_addr(c_addr), .commit_data(c_data),
    .commit_kind(c_kind)
  );

  wwc_outreg #(.ADDR_W(ADDR_W)) u_out (
    .clk(clk), .rst(rst),
    .commit(c_commit), .commit_addr(c_addr), .commit_data(c_data),
    .commit_kind(c_kind),
    .direct_en(host_wr_en && dec_kind == KIND_NARROW),
    .direct_addr(host_addr), .direct_data(host_wdata),
    .wide_we(wide_we), .wide_addr(wide_addr), .wide_data(wide_data),
    .wide_kind(wide_kind), .narrow_we(narrow_we),
    .narrow_addr(narrow_addr), .narrow_data(narrow_data)
  );

  // R8: direct registers pass through one cycle later without a wide write
  a_r8_direct_pass: assert property (@(posedge clk) disable iff (rst)
    (host_wr_en && dec_kind == KIND_NARROW)
      |=> (narrow_we && !wide_we && narrow_addr == $past(host_addr)));

  // R6: a descriptor top dword always commits
  a_r6_desc_top_commits: assert property (@(posedge clk) disable iff (rst)
    (host_wr_en && dec_kind == KIND_DESC && dec_top)
      |=> (wide_we && wide_kind == 2'd2));

  // R5: memory-word commits carry zero upper half
  a_r5_mem_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (wide_we && wide_kind == 2'd1) |-> (wide_data[127:64] == '0));

  // R2: 128-bit commits are 16-byte aligned
  a_r2_aligned: assert property (@(posedge clk) disable iff (rst)
    (wide_we && wide_kind != 2'd1) |-> (wide_addr[3:0] == 4'h0));
endmodule

// File: tb/wide_write_collector_bench.sv
`timescale 1ns/1ps
module wide_write_collector_bench;
  logic         clk = 1'b0;
  logic         rst;
  logic         host_wr_en;
  logic [23:0]  host_addr;
  logic [31:0]  host_wdata;
  logic         wide_we, narrow_we;
  logic [23:0]  wide_addr, narrow_addr;
  logic [127:0] wide_data;
  logic [1:0]   wide_kind;
  logic [31:0]  narrow_data;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  wide_write_collector u_wide_write_collector (
    .clk(clk), .rst(rst), .host_wr_en(host_wr_en), .host_addr(host_addr),
    .host_wdata(host_wdata), .wide_we(wide_we), .wide_addr(wide_addr),
    .wide_data(wide_data), .wide_kind(wide_kind), .narrow_we(narrow_we),
    .narrow_addr(narrow_addr), .narrow_data(narrow_data)
  );

  localparam logic [23:0] REG_A  = 24'h000100;
  localparam logic [23:0] REG_B  = 24'h000200;
  localparam logic [23:0] MEM_W  = 24'h800040;
  localparam logic [23:0] RXD_P3 = 24'h006830;
  localparam logic [23:0] TXD_P1 = 24'h002A10;

  task automatic wr(input logic [23:0] a, input logic [31:0] d);
    @(negedge clk);
    host_wr_en = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr_en = 1'b0;
  endtask

  task automatic chk_none(input string req);
    n_chk++;
    if (wide_we !== 1'b0) begin
      n_bad++;
      $display("FAIL %s: wide_we=%b expected 0", req, wide_we);
    end
  endtask

  task automatic chk_commit(input string req, input logic [23:0] a,
                            input logic [127:0] d, input logic [1:0] k);
    n_chk++;
    if (wide_we !== 1'b1 || wide_addr !== a || wide_data !== d || wide_kind !== k) begin
      n_bad++;
      $display("FAIL %s: we=%b addr=%h data=%h kind=%0d expected we=1 addr=%h data=%h kind=%0d",
               req, wide_we, wide_addr, wide_data, wide_kind, a, d, k);
    end
  endtask

  task automatic chk_narrow(input string req, input logic exp_we,
                            input logic [23:0] a, input logic [31:0] d);
    n_chk++;
    if (narrow_we !== exp_we || (exp_we && (narrow_addr !== a || narrow_data !== d))) begin
      n_bad++;
      $display("FAIL %s: nwe=%b addr=%h data=%h expected nwe=%b addr=%h data=%h",
               req, narrow_we, narrow_addr, narrow_data, exp_we, a, d);
    end
  endtask

  task automatic t_reset;
    n_chk++;
    if (wide_we !== 1'b0 || narrow_we !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: wide_we=%b narrow_we=%b expected 0 0", wide_we, narrow_we);
    end
    wr(RXD_P3 + 24'hC, 32'hD00D_0001);
    chk_commit("R1 empty after reset", RXD_P3, {32'hD00D_0001, 96'h0}, 2'd2);
  endtask

  task automatic t_reg128;
    wr(REG_A + 24'h8, 32'hA2A2_0002); chk_none("R3 one dword");
    wr(REG_A + 24'h0, 32'hBAD0_0000); chk_none("R3 two dwords");
    wr(REG_A + 24'hC, 32'hA3A3_0003); chk_none("R3 three dwords");
    wr(REG_A + 24'h0, 32'hA0A0_0000); chk_none("R3 rewrite dword");
    wr(REG_A + 24'h4, 32'hA1A1_0001);
    chk_commit("R2 four dwords", REG_A,
               {32'hA3A3_0003, 32'hA2A2_0002, 32'hA1A1_0001, 32'hA0A0_0000}, 2'd0);
    @(negedge clk); chk_none("R10 single pulse");
    wr(REG_A + 24'h4, 32'h1111_1111);
    wr(REG_A + 24'h8, 32'h2222_2222);
    wr(REG_A + 24'hC, 32'h3333_3333); chk_none("R10 emptied after commit");
    wr(REG_A + 24'h0, 32'h0);
    chk_commit("R10 fresh fill", REG_A,
               {32'h3333_3333, 32'h2222_2222, 32'h1111_1111, 32'h0}, 2'd0);
  endtask

  task automatic t_restart;
    wr(REG_A + 24'h0, 32'h10);
    wr(REG_A + 24'h4, 32'h11);
    wr(REG_A + 24'h8, 32'h12);
    wr(REG_B + 24'h0, 32'h20);
    wr(REG_A + 24'hC, 32'h13); chk_none("R4 earlier dwords lost");
    wr(REG_A + 24'h0, 32'h30);
    wr(REG_A + 24'h4, 32'h31);
    wr(REG_A + 24'h8, 32'h32);
    chk_commit("R4 refill after restart", REG_A,
               {32'h13, 32'h32, 32'h31, 32'h30}, 2'd0);
  endtask

  task automatic t_mem;
    wr(MEM_W + 24'h4, 32'hCAFE_0001); chk_none("R5 half word");
    wr(MEM_W + 24'h0, 32'hCAFE_0000);
    chk_commit("R5 memory word", MEM_W, {64'h0, 32'hCAFE_0001, 32'hCAFE_0000}, 2'd1);
    wr(MEM_W + 24'h8, 32'h5);
    wr(MEM_W + 24'hC, 32'h6);
    chk_commit("R5 second word", MEM_W + 24'h8, {64'h0, 32'h6, 32'h5}, 2'd1);
  endtask

  task automatic t_desc;
    wr(TXD_P1 + 24'h0, 32'hE000_0000);
    wr(TXD_P1 + 24'h8, 32'hE000_0002);
    wr(TXD_P1 + 24'hC, 32'hE000_0003);
    chk_commit("R6 partial zero fill", TXD_P1,
               {32'hE000_0003, 32'hE000_0002, 32'h0, 32'hE000_0000}, 2'd2);
  endtask

  task automatic t_discard;
    wr(REG_A + 24'h0, 32'h40);
    wr(REG_A + 24'h4, 32'h41);
    wr(RXD_P3 + 24'h4, 32'hF00D); chk_none("R7 discarded dword");
    wr(REG_A + 24'h8, 32'h42);
    wr(REG_A + 24'hC, 32'h43);
    chk_commit("R7 collector kept", REG_A, {32'h43, 32'h42, 32'h41, 32'h40}, 2'd0);
    wr(RXD_P3 + 24'hC, 32'h77);
    chk_commit("R7 dropped dword absent", RXD_P3, {32'h77, 96'h0}, 2'd2);
  endtask

  task automatic t_direct;
    wr(24'h00A400, 32'h1234_5678);
    chk_narrow("R8 direct 0x400", 1'b1, 24'h00A400, 32'h1234_5678);
    chk_none("R8 no wide write");
    wr(REG_A + 24'h0, 32'h50);
    wr(REG_A + 24'h4, 32'h51);
    wr(REG_A + 24'h8, 32'h52);
    wr(24'h004420, 32'h9);
    chk_narrow("R8 timer other page", 1'b1, 24'h004420, 32'h9);
    wr(REG_A + 24'hC, 32'h53);
    chk_commit("R8 collector unaffected", REG_A, {32'h53, 32'h52, 32'h51, 32'h50}, 2'd0);
    chk_narrow("R8 strobe one cycle", 1'b0, 24'h0, 32'h0);
  endtask

  task automatic t_timer;
    wr(REG_A + 24'h0, 32'h60);
    wr(REG_A + 24'h4, 32'h61);
    wr(REG_A + 24'h8, 32'h62);
    wr(24'h000420, 32'h1);
    chk_narrow("R9 timer forwarded", 1'b1, 24'h000420, 32'h1);
    wr(REG_A + 24'hC, 32'h63); chk_none("R9 collector emptied");
    wr(REG_A + 24'h0, 32'h70);
    wr(REG_A + 24'h4, 32'h71);
    wr(REG_A + 24'h8, 32'h72);
    chk_commit("R9 refill", REG_A, {32'h63, 32'h72, 32'h71, 32'h70}, 2'd0);
  endtask

  initial begin
    #(200000 * 8);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; host_wr_en = 1'b0; host_addr = '0; host_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_reg128();
    t_restart();
    t_mem();
    t_desc();
    t_discard();
    t_direct();
    t_timer();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule